// File: doc/BRIEF.md
# Byte-Wide SPI Serial Engine with Write-Collision Detection

This block moves one byte at a time over a four-wire SPI link. It can act as the link's master or as one of its slaves. Software sees three register-style accesses. A control write selects the role, the clock polarity, the clock phase and the bit order. A data write supplies the byte to send. A status read sets up the clearing of the two flags: transfer complete and write collision. The received byte is always available on a parallel output.

In master mode a data write starts a transfer. The shift clock is derived from the system clock by a parameterized divider (`DIV` system clocks per shift-clock period, at least 4 and even). Slave-select is held low for the whole byte. In slave mode the external shift clock and slave-select pass through a two-flop synchronizer before edge detection. The byte written beforehand is loaded into the shifter when slave-select falls. The engine supports both phase settings. With phase 0, the first bit leads the clock by half a period. With phase 1, data changes on the first edge of each bit and is captured on the second edge.

Top module: `spi_xcvr`

## Requirements
- R1: While no transfer is running, `sclk_out` rests at the polarity bit (control bit 1): low for 0, high for 1. This holds in both roles.
- R2: With phase 0 (control bit 0 = 0), the first bit is already on the data output when slave-select goes low. The first clock edge follows DIV/2 system clocks later. Bits are captured on the leading (idle-to-active) edge and changed on the trailing edge.
- R3: With phase 1 (control bit 0 = 1), the data output changes on the leading edge of each bit and input is captured on the trailing edge.
- R4: A master transfer has exactly 16 clock edges (8 clock cycles). `ss_n_out` stays low throughout and rises DIV/2 system clocks after the 16th edge.
- R5: Control bit 2 selects the bit order: 0 sends bit 7 first, 1 sends bit 0 first. Received bits are assembled in the same order, so `rx_byte` holds the byte in its natural bit positions.
- R6: In master mode (control bit 3 = 1), a data write while `ss_n_out` is high starts a transfer. `ss_n_out` is low one system clock later.
- R7: `done_flag` rises after the last bit of a transfer, at the same time `rx_byte` is updated. It then stays set until the clear sequence of R9.
- R8: A data write while slave-select is active (own `ss_n_out` in master mode, synchronized `ss_n_in` in slave mode) sets `wcol_flag`. It leaves the byte being shifted out and the byte being received unchanged.
- R9: A status read followed by a data write or data read clears both flags. A data access without a preceding status read leaves them set.
- R10: In slave mode (control bit 3 = 0), the byte written while `ss_n_in` was high is shifted out on `miso_out` after `ss_n_in` falls. The byte received on `mosi_in` appears on `rx_byte`. `ss_n_out` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control value: bit 3 master, bit 2 LSB first, bit 1 polarity, bit 0 phase |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rd | input | 1 | Data register read strobe (used for flag clearing) |
| sts_rd | input | 1 | Status register read strobe |
| rx_byte | output | 8 | Last received byte |
| done_flag | output | 1 | Sticky transfer-complete flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| sclk_out | output | 1 | Shift clock driven in master mode |
| ss_n_out | output | 1 | Active-low slave-select driven in master mode |
| mosi_out | output | 1 | Master serial data out |
| miso_in | input | 1 | Master serial data in |
| sclk_in | input | 1 | External shift clock in slave mode |
| ss_n_in | input | 1 | External active-low slave-select in slave mode |
| mosi_in | input | 1 | Slave serial data in |
| miso_out | output | 1 | Slave serial data out, 0 when not selected |

## Verification
The assertions on clock idle level and flag behaviour assume the control register is rewritten only while no transfer runs. They also assume the role is not changed while slave-select is active. In slave mode, correct capture further relies on the external clock's half-period being comfortably longer than the three-cycle synchronizer and edge-detect latency, and on slave-select being held low across all 16 edges. The stimulus writes control only between transfers. It drives the external clock with 8-system-clock half-periods and a matching lead and lag on slave-select, and it changes serial inputs only on the opposite edge from the capture edge.

// File: rtl/spi_xcvr_pkg.sv
// Package: shared word width and control register layout for the SPI engine.
// Assumes: a packed struct places its first member in the most significant bit.
package spi_xcvr_pkg;

    localparam int WORD_W = 8;

    // Control register image: bit 3 role, bit 2 order, bit 1 polarity, bit 0 phase
    typedef struct packed {
        logic master;
        logic lsb_first;
        logic cpol;
        logic cpha;
    } ctl_t;

endpackage

// File: rtl/spi_sync.sv
// Module: spi_sync
// Two-flop synchronizer for a small vector of asynchronous pins.
// Assumes: each bit is independent; RST_VAL is the idle level of each pin.
module spi_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage resampling into the system clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;

endmodule

// File: rtl/spi_mclk.sv
// Module: spi_mclk
// Master-mode timing: a half-period ticker driving 16 clock edges and a
// frame-wide slave-select, ending one half-period after the last edge.
// Assumes: DIV is even and at least 4; cpol is stable during a frame.
module spi_mclk #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cpol,
    output logic sclk,
    output logic ss_n,
    output logic lead,
    output logic trail,
    output logic fin
);

    localparam int HALF  = DIV / 2;
    localparam int CW    = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int EDGES = 16;
    localparam logic [CW-1:0] HLAST = CW'(HALF - 1);
    localparam logic [4:0]    ELAST = 5'(EDGES);

    logic          busy_q;
    logic [CW-1:0] hcnt_q;
    logic [4:0]    ecnt_q;
    logic          sclk_q;
    logic          ss_q;
    logic          tick;
    logic          more;

    assign tick = busy_q && (hcnt_q == HLAST);
    assign more = (ecnt_q < ELAST);

    // Frame sequencer: half-period counter, edge counter, clock and select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            hcnt_q <= '0;
            ecnt_q <= '0;
            sclk_q <= 1'b0;
            ss_q   <= 1'b1;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            hcnt_q <= '0;
            ecnt_q <= '0;
            sclk_q <= cpol;
            ss_q   <= 1'b0;
        end else if (busy_q) begin
            hcnt_q <= tick ? '0 : hcnt_q + 1'b1;
            if (tick) begin
                if (more) begin
                    sclk_q <= ~sclk_q;
                    ecnt_q <= ecnt_q + 1'b1;
                end else begin
                    busy_q <= 1'b0;
                    ss_q   <= 1'b1;
                end
            end
        end else begin
            sclk_q <= cpol;
        end
    end

    assign lead  = tick && more && !ecnt_q[0];
    assign trail = tick && more && ecnt_q[0];
    assign fin   = tick && !more;
    assign sclk  = sclk_q;
    assign ss_n  = ss_q;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && $past(!busy_q) && $stable(cpol)) |-> (sclk_q == cpol))
        else $error("idle clock level differs from polarity"); // R1
    AST_CLOCK_BACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !more) |-> (sclk_q == cpol))
        else $error("clock not at idle level after 16 edges"); // R4
    AST_SS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> ss_q)
        else $error("select not released at frame end"); // R4

endmodule

// File: rtl/spi_shreg.sv
// Module: spi_shreg
// Separate transmit and receive shifters with a selectable bit order.
// Assumes: load, shift_ev and samp_ev are single-cycle pulses.
module spi_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_data,
    input  logic         lsb_first,
    input  logic         shift_ev,
    input  logic         samp_ev,
    input  logic         in_bit,
    output logic         out_bit,
    output logic [W-1:0] rx_word
);

    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    // Transmit shifter: load a word, then move the next bit to the output end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= ld_data;
        end else if (shift_ev) begin
            tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
        end
    end

    // Receive shifter: insert each captured bit from the side matching the order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (load) begin
            rx_q <= '0;
        end else if (samp_ev) begin
            rx_q <= lsb_first ? {in_bit, rx_q[W-1:1]} : {rx_q[W-2:0], in_bit};
        end
    end

    assign out_bit = lsb_first ? tx_q[0] : tx_q[W-1];
    assign rx_word = rx_q;

endmodule

// File: rtl/spi_xcvr.sv
// Module: spi_xcvr
// Byte-wide SPI engine, master or slave, with control, data and status access,
// a sticky completion flag and a write-collision flag.
// Assumes: control is rewritten only while slave-select is inactive; in slave
// mode the external clock half-period exceeds the 3-cycle sync latency.
module spi_xcvr
    import spi_xcvr_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [3:0]        ctl_wdata,
    input  logic              dat_wr,
    input  logic [WORD_W-1:0] dat_wdata,
    input  logic              dat_rd,
    input  logic              sts_rd,
    output logic [WORD_W-1:0] rx_byte,
    output logic              done_flag,
    output logic              wcol_flag,
    output logic              sclk_out,
    output logic              ss_n_out,
    output logic              mosi_out,
    input  logic              miso_in,
    input  logic              sclk_in,
    input  logic              ss_n_in,
    input  logic              mosi_in,
    output logic              miso_out
);

    localparam logic [1:0] PIN_IDLE = 2'b10;

    ctl_t              ctl_q;
    logic [WORD_W-1:0] tx_hold_q;
    logic [WORD_W-1:0] rx_hold_q;
    logic              done_q;
    logic              wcol_q;
    logic              clr_arm_q;
    logic              fin_q;
    logic              m_sclk, m_ss_n, m_lead, m_trail, m_fin, m_start;
    logic [1:0]        pin_s;
    logic              ss_s, sclk_s, ss_d_q, sclk_d_q;
    logic              sel, s_start, s_lead, s_trail, s_fin;
    logic [2:0]        scnt_q;
    logic              lead, trail, samp_ev, shift_ev, seen_q, load;
    logic              out_bit, in_bit, ss_act, coll, clr, data_acc;
    logic [WORD_W-1:0] rx_word;

    // Control register capture
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_t'(ctl_wdata);
    end

    assign m_start = ctl_q.master && dat_wr && m_ss_n;

    spi_mclk #(.DIV(DIV)) u_mclk (
        .clk   (clk),
        .rst_n (rst_n),
        .start (m_start),
        .cpol  (ctl_q.cpol),
        .sclk  (m_sclk),
        .ss_n  (m_ss_n),
        .lead  (m_lead),
        .trail (m_trail),
        .fin   (m_fin)
    );

    spi_sync #(.W(2), .RST_VAL(PIN_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ss_n_in, sclk_in}),
        .q_sync  (pin_s)
    );

    assign ss_s   = pin_s[1];
    assign sclk_s = pin_s[0];

    // Previous synchronized pin values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_d_q   <= 1'b1;
            sclk_d_q <= 1'b0;
        end else begin
            ss_d_q   <= ss_s;
            sclk_d_q <= sclk_s;
        end
    end

    assign sel     = !ctl_q.master && !ss_s;
    assign s_start = sel && ss_d_q;
    assign s_lead  = sel && (sclk_s != sclk_d_q) && (sclk_d_q == ctl_q.cpol);
    assign s_trail = sel && (sclk_s != sclk_d_q) && (sclk_s == ctl_q.cpol);
    assign s_fin   = s_trail && (scnt_q == 3'd7);

    // Slave trailing-edge counter, restarted at each select
    always_ff @(posedge clk) begin
        if (!rst_n)       scnt_q <= '0;
        else if (s_start) scnt_q <= '0;
        else if (s_trail) scnt_q <= scnt_q + 1'b1;
    end

    assign lead     = m_lead || s_lead;
    assign trail    = m_trail || s_trail;
    assign load     = m_start || s_start;
    assign samp_ev  = ctl_q.cpha ? trail : lead;
    assign shift_ev = ctl_q.cpha ? (lead && seen_q) : trail;
    assign in_bit   = ctl_q.master ? miso_in : mosi_in;

    // First-leading-edge marker for the phase-1 output timing
    always_ff @(posedge clk) begin
        if (!rst_n)    seen_q <= 1'b0;
        else if (load) seen_q <= 1'b0;
        else if (lead) seen_q <= 1'b1;
    end

    spi_shreg #(.W(WORD_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_data   (ctl_q.master ? dat_wdata : tx_hold_q),
        .lsb_first (ctl_q.lsb_first),
        .shift_ev  (shift_ev),
        .samp_ev   (samp_ev),
        .in_bit    (in_bit),
        .out_bit   (out_bit),
        .rx_word   (rx_word)
    );

    assign ss_act   = ctl_q.master ? !m_ss_n : !ss_s;
    assign coll     = dat_wr && ss_act;
    assign data_acc = dat_wr || dat_rd;
    assign clr      = clr_arm_q && data_acc;

    // Transmit holding register, written only when no frame is active
    always_ff @(posedge clk) begin
        if (!rst_n)                 tx_hold_q <= '0;
        else if (dat_wr && !ss_act) tx_hold_q <= dat_wdata;
    end

    // Completion pipeline and received-byte capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q     <= 1'b0;
            rx_hold_q <= '0;
        end else begin
            fin_q <= m_fin || s_fin;
            if (fin_q) rx_hold_q <= rx_word;
        end
    end

    // Sticky flags with status-then-data clearing; set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            wcol_q    <= 1'b0;
            clr_arm_q <= 1'b0;
        end else begin
            if (fin_q)    done_q <= 1'b1;
            else if (clr) done_q <= 1'b0;
            if (coll)     wcol_q <= 1'b1;
            else if (clr) wcol_q <= 1'b0;
            if (sts_rd)        clr_arm_q <= 1'b1;
            else if (data_acc) clr_arm_q <= 1'b0;
        end
    end

    AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        coll |=> wcol_q)
        else $error("collision write did not raise flag"); // R8
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr) |=> done_q)
        else $error("completion flag dropped without clear"); // R7

    assign rx_byte   = rx_hold_q;
    assign done_flag = done_q;
    assign wcol_flag = wcol_q;
    assign sclk_out  = m_sclk;
    assign ss_n_out  = m_ss_n;
    assign mosi_out  = (ctl_q.master && !m_ss_n) ? (out_bit && (!ctl_q.cpha || seen_q)) : 1'b0;
    assign miso_out  = sel ? (out_bit && (!ctl_q.cpha || seen_q)) : 1'b0;

endmodule

// File: tb/test_spi_xcvr.sv
// Directed bench for spi_xcvr: the bench acts as remote slave in master mode
// and as remote master in slave mode.
module test_spi_xcvr;

    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;
    localparam int SH   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic       dat_wr = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic       dat_rd = 1'b0;
    logic       sts_rd = 1'b0;
    logic [7:0] rx_byte;
    logic       done_flag, wcol_flag, sclk_out, ss_n_out, mosi_out, miso_out;
    logic       miso_in = 1'b0;
    logic       sclk_in = 1'b0;
    logic       ss_n_in = 1'b1;
    logic       mosi_in = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spi_xcvr #(.DIV(DIV)) i_spi_xcvr (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .sts_rd(sts_rd),
        .rx_byte(rx_byte), .done_flag(done_flag), .wcol_flag(wcol_flag),
        .sclk_out(sclk_out), .ss_n_out(ss_n_out), .mosi_out(mosi_out), .miso_in(miso_in),
        .sclk_in(sclk_in), .ss_n_in(ss_n_in), .mosi_in(mosi_in), .miso_out(miso_out)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ctl(input bit m, input bit lsb, input bit cpol, input bit cpha);
        ctl_wdata = {m, lsb, cpol, cpha};
        ctl_wr = 1'b1;
        tick();
        ctl_wr = 1'b0;
        tick();
    endtask

    task automatic write_data(input logic [7:0] d);
        dat_wdata = d;
        dat_wr = 1'b1;
        tick();
        dat_wr = 1'b0;
    endtask

    function automatic logic sbit(input logic [7:0] w, input bit lsb, input int k);
        return lsb ? w[k] : w[7-k];
    endfunction

    // Reset state of all outputs
    task automatic t_reset();
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        chk(sclk_out == 1'b0, "R1", "reset sclk_out", int'(sclk_out), 0);
        chk(ss_n_out == 1'b1, "R4", "reset ss_n_out", int'(ss_n_out), 1);
        chk(done_flag == 1'b0, "R7", "reset done_flag", int'(done_flag), 0);
        chk(wcol_flag == 1'b0, "R8", "reset wcol_flag", int'(wcol_flag), 0);
        chk(rx_byte == 8'h00, "R5", "reset rx_byte", int'(rx_byte), 0);
    endtask

    // Sticky completion, then the clear sequence with and without status read
    task automatic t_clear(input bit exp_wcol);
        repeat (10) tick();
        chk(done_flag == 1'b1, "R7", "done sticky", int'(done_flag), 1);
        dat_rd = 1'b1; tick(); dat_rd = 1'b0; tick();
        chk(done_flag == 1'b1, "R9", "done kept without status read", int'(done_flag), 1);
        chk(wcol_flag == exp_wcol, "R9", "wcol kept without status read", int'(wcol_flag), int'(exp_wcol));
        sts_rd = 1'b1; tick(); sts_rd = 1'b0;
        dat_rd = 1'b1; tick(); dat_rd = 1'b0; tick();
        chk(done_flag == 1'b0, "R9", "done cleared", int'(done_flag), 0);
        chk(wcol_flag == 1'b0, "R9", "wcol cleared", int'(wcol_flag), 0);
    endtask

    // Master transfer with the bench as the remote slave
    task automatic t_master(input logic [7:0] tx, input logic [7:0] pat, input bit cpol,
                            input bit cpha, input bit lsb, input bit collide);
        int   edges, k, cyc, first, last;
        bit   prev, lead;
        logic [7:0] got;
        string rq;
        rq = cpha ? "R3/R5" : "R2/R5";
        wr_ctl(1'b1, lsb, cpol, cpha);
        chk(sclk_out == cpol, "R1", "master idle level", int'(sclk_out), int'(cpol));
        miso_in = sbit(pat, lsb, 0);
        write_data(tx);
        chk(ss_n_out == 1'b0, "R6", "select low after write", int'(ss_n_out), 0);
        if (!cpha) chk(mosi_out == sbit(tx, lsb, 0), "R2", "first bit leads clock", int'(mosi_out), int'(sbit(tx, lsb, 0)));
        prev = cpol; edges = 0; k = 0; cyc = 0; first = -1; last = 0; got = '0;
        while (ss_n_out == 1'b0 && cyc < 400) begin
            tick();
            cyc++;
            if (collide && cyc == 3 * HALF) begin
                dat_wdata = ~tx;
                dat_wr = 1'b1;
            end else begin
                dat_wr = 1'b0;
            end
            if (sclk_out != prev) begin
                edges++;
                prev = sclk_out;
                if (first < 0) first = cyc;
                last = cyc;
                lead = (edges % 2) == 1;
                if (lead != cpha) begin
                    if (k < 8) begin
                        if (lsb) got[k] = mosi_out; else got[7-k] = mosi_out;
                        k++;
                    end
                end else if (k < 8) begin
                    miso_in = sbit(pat, lsb, k);
                end
            end
        end
        dat_wr = 1'b0;
        chk(edges == 16, "R4", "edge count", edges, 16);
        chk(first == HALF, "R2", "first edge delay", first, HALF);
        chk(cyc - last == HALF, "R4", "select release delay", cyc - last, HALF);
        chk(got == tx, rq, "mosi word", int'(got), int'(tx));
        tick(); tick();
        chk(done_flag == 1'b1, "R7", "done after master frame", int'(done_flag), 1);
        chk(rx_byte == pat, rq, "master rx_byte", int'(rx_byte), int'(pat));
        chk(wcol_flag == collide, "R8", "master wcol", int'(wcol_flag), int'(collide));
        chk(sclk_out == cpol, "R1", "idle level after frame", int'(sclk_out), int'(cpol));
        t_clear(collide);
    endtask

    // Slave transfer with the bench as the remote master
    task automatic t_slave(input logic [7:0] pre, input logic [7:0] pat, input bit cpol,
                           input bit cpha, input bit lsb, input bit collide);
        logic [7:0] got;
        string rq;
        rq = cpha ? "R10/R3/R5" : "R10/R2/R5";
        sclk_in = cpol;
        ss_n_in = 1'b1;
        wr_ctl(1'b0, lsb, cpol, cpha);
        repeat (4) tick();
        chk(sclk_out == cpol, "R1", "slave-mode idle level", int'(sclk_out), int'(cpol));
        chk(ss_n_out == 1'b1, "R10", "slave-mode ss_n_out", int'(ss_n_out), 1);
        write_data(pre);
        tick();
        chk(wcol_flag == 1'b0, "R8", "no collision while deselected", int'(wcol_flag), 0);
        got = '0;
        mosi_in = sbit(pat, lsb, 0);
        ss_n_in = 1'b0;
        repeat (SH) tick();
        for (int b = 0; b < 8; b++) begin
            if (!cpha) begin
                if (lsb) got[b] = miso_out; else got[7-b] = miso_out;
            end
            sclk_in = ~cpol;
            if (cpha) mosi_in = sbit(pat, lsb, b);
            if (collide && b == 4) begin
                dat_wdata = ~pre;
                dat_wr = 1'b1;
                tick();
                dat_wr = 1'b0;
                repeat (SH - 1) tick();
            end else begin
                repeat (SH) tick();
            end
            if (cpha) begin
                if (lsb) got[b] = miso_out; else got[7-b] = miso_out;
            end
            sclk_in = cpol;
            if (!cpha && b < 7) mosi_in = sbit(pat, lsb, b + 1);
            repeat (SH) tick();
        end
        ss_n_in = 1'b1;
        repeat (6) tick();
        chk(got == pre, rq, "miso word", int'(got), int'(pre));
        chk(rx_byte == pat, rq, "slave rx_byte", int'(rx_byte), int'(pat));
        chk(done_flag == 1'b1, "R7", "done after slave frame", int'(done_flag), 1);
        chk(wcol_flag == collide, "R8", "slave wcol", int'(wcol_flag), int'(collide));
        chk(miso_out == 1'b0, "R10", "miso quiet when deselected", int'(miso_out), 0);
        t_clear(collide);
    endtask

    initial begin
        t_reset();
        t_master(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
        t_master(8'h96, 8'hE1, 1'b1, 1'b0, 1'b1, 1'b0);
        t_master(8'h5A, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b0);
        t_master(8'h81, 8'h7E, 1'b1, 1'b1, 1'b1, 1'b1);
        t_slave(8'hD2, 8'h4B, 1'b0, 1'b0, 1'b0, 1'b0);
        t_slave(8'h1F, 8'hE8, 1'b1, 1'b1, 1'b1, 1'b1);
        t_slave(8'h6C, 8'h35, 1'b0, 1'b1, 1'b0, 1'b0);
        t_slave(8'hB4, 8'h0F, 1'b1, 1'b0, 1'b1, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule